// File: doc/BRIEF.md
# Byte-Burst SPI Master with Gated Configuration

This block is an SPI master driven through a small 32-bit register window. It has two operating modes. In configuration mode the framing controls (bit order, clock polarity, clock phase, clock divider) may be changed, and a flush request empties both byte queues. In active mode the framing controls are frozen and bytes written to the data register are shifted out on `mosi` while `miso` is captured.

Software loads a burst of up to four bytes into the transmit queue. Each byte is serialised as an 8-bit frame, and each received frame is pushed into a four-entry receive queue that software drains by reading the data register. A receive fill-level threshold and its enable stay writable in active mode, so a driver can set them for each burst. The interrupt output rises once the receive queue holds at least that many bytes. The queue depth `DEPTH` must be a power of two.

Top module: `spi_burst_master`

Register offsets: mode 0x00, framing 0x04, clock 0x08, status 0x0C, data 0x10.

## Requirements
- R1: After reset the block is in configuration mode (mode register reads 0), the status register reads 1 (idle only), `sck` is 0 and `irq` is 0.
- R2: Mode register bit0 selects active (1) or configuration (0). Writing bit0=0 with bit1=1 empties both queues and clears the overflow flag. While in configuration mode, data-register writes are discarded and no frame is shifted. Entering configuration mode aborts a frame in flight.
- R3: Framing register fields are bit0 LSB-first, bit1 clock polarity, bit2 clock phase, bit3 receive-interrupt enable, and bits[13:12] threshold minus one. Bits[2:0] of the framing register and the clock-register divider bits[15:8] keep their values when written in active mode. Bits 3 and [13:12] are writable in either mode.
- R4: Each `sck` half-period lasts divider+1 input clocks, and `sck` rests at the clock-polarity level between frames.
- R5: Frames are 8 bits, sent MSB first when bit0 of the framing register is 0 and LSB first when it is 1.
- R6: In all four polarity/phase combinations, the received byte equals the bits presented on `miso` at the sampling edges. The sampling edge is the leading edge when phase is 0 and the trailing edge when phase is 1.
- R7: Each queue holds 4 bytes. A data write to a full transmit queue is dropped and sets sticky status bit3.
- R8: Reading the data register pops the receive queue. Reading an empty queue returns 0. Status bit2 is 1 while the receive queue is non-empty.
- R9: Status bit1 is 1 when the receive count is at least threshold field + 1. `irq` equals status bit1 AND the enable bit.
- R10: Status bit0 is 1 when no frame is shifting and the transmit queue is empty.
- R11: Clock register bits[4:0] read back the fixed frame length 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive queue at data offset) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Receive threshold interrupt |

## Verification
The bench builds the block with its defaults, `DEPTH`=4 and `DIV_W`=8. The shallow queue lets six back-to-back writes reach the overflow boundary, while a slow divider keeps the shifter busy. The divider values 0 to 3 are programmed through the clock register, which keeps every frame short enough to sweep all four polarity/phase modes with both bit orders. The bench loops `miso` back inverted from `mosi` and records `mosi` at its own sampling edges, so transmit order and receive capture are checked separately.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [4:0] A_MODE = 5'h00, A_FRM = 5'h04, A_CLK = 5'h08,
                         A_STAT = 5'h0C, A_DATA = 5'h10;

  logic             active, lsb_first, cpol, cpha, rxie, ovf;
  logic [PW-1:0]    thr_m1;
  logic [DIV_W-1:0] div;

  logic [7:0]    txq [DEPTH];
  logic [7:0]    rxq [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  logic             busy, lvl;
  logic [3:0]       edge_n;
  logic [DIV_W-1:0] hcnt;
  logic [7:0]       tx_sh, rx_sh, rx_next;

  wire wr_mode  = bus_wr && bus_addr == A_MODE;
  wire to_cfg   = wr_mode && !bus_wdata[0];
  wire flush    = to_cfg && bus_wdata[1];
  wire tx_req   = bus_wr && bus_addr == A_DATA && active;
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire tx_push  = tx_req && !tx_full && !flush;
  wire start    = active && !busy && tx_cnt != '0 && !to_cfg;
  wire tick     = busy && hcnt == div;
  wire sample   = tick && edge_n[0] == cpha;
  wire shift    = tick && edge_n[0] != cpha && edge_n != 4'd0;
  wire done     = tick && edge_n == 4'd15 && !to_cfg;
  wire rx_push  = done && rx_cnt != CW'(DEPTH);
  wire rx_pop   = bus_rd && bus_addr == A_DATA && rx_cnt != '0 && !flush;
  wire rx_hit   = rx_cnt > CW'(thr_m1);
  wire idle     = !busy && tx_cnt == '0;

  assign rx_next = !sample ? rx_sh : lsb_first ? {miso, rx_sh[7:1]} : {rx_sh[6:0], miso};
  assign sck  = cpol ^ lvl;
  assign mosi = lsb_first ? tx_sh[0] : tx_sh[7];
  assign irq  = rxie && rx_hit;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE: bus_rdata[0] = active;
      A_FRM:  begin
        bus_rdata[3:0] = {rxie, cpha, cpol, lsb_first};
        bus_rdata[12 +: PW] = thr_m1;
      end
      A_CLK:  begin
        bus_rdata[8 +: DIV_W] = div;
        bus_rdata[4:0] = 5'd8;
      end
      A_STAT: bus_rdata[3:0] = {ovf, rx_cnt != '0, rx_hit, idle};
      A_DATA: if (rx_cnt != '0) bus_rdata[7:0] = rxq[rx_rp];
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; lsb_first <= 1'b0; cpol <= 1'b0; cpha <= 1'b0;
      rxie <= 1'b0; thr_m1 <= '0; div <= '0; ovf <= 1'b0;
    end else begin
      if (wr_mode) active <= bus_wdata[0];
      if (bus_wr && bus_addr == A_FRM) begin
        rxie   <= bus_wdata[3];
        thr_m1 <= bus_wdata[12 +: PW];
        if (!active) {cpha, cpol, lsb_first} <= bus_wdata[2:0];
      end
      if (bus_wr && bus_addr == A_CLK && !active) div <= bus_wdata[8 +: DIV_W];
      if (flush) ovf <= 1'b0;
      else if (tx_req && tx_full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (start)   tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(start);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txq[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rxq[rx_wp] <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lvl <= 1'b0; edge_n <= '0; hcnt <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (to_cfg) begin
      busy <= 1'b0; lvl <= 1'b0; edge_n <= '0; hcnt <= '0;
    end else if (start) begin
      busy <= 1'b1; lvl <= 1'b0; edge_n <= '0; hcnt <= '0;
      tx_sh <= txq[tx_rp];
    end else if (busy) begin
      rx_sh <= rx_next;
      if (shift) tx_sh <= lsb_first ? tx_sh >> 1 : tx_sh << 1;
      if (tick) begin
        hcnt   <= '0;
        lvl    <= ~lvl;
        edge_n <= edge_n + 1'b1;
        if (edge_n == 4'd15) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         active,
  input logic                         busy,
  input logic                         sck,
  input logic                         cpol,
  input logic                         irq,
  input logic                         flush,
  input logic [$clog2(DEPTH+1)-1:0]   tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0]   rx_cnt,
  input logic [$clog2(DEPTH)-1:0]     thr_m1,
  input logic [DIV_W-1:0]             div
);
  // R4
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sck == cpol);
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> rx_cnt > {1'b0, thr_m1});
  // R7
  tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= DEPTH && rx_cnt <= DEPTH);
  // R3
  div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) active |=> $stable(div));
  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) flush |=> tx_cnt == 0 && rx_cnt == 0);
  // R2
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !busy);
endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .active(active), .busy(busy), .sck(sck), .cpol(cpol),
  .irq(irq), .flush(flush), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .thr_m1(thr_m1), .div(div)
);

// File: tb/spi_burst_master_tb_top.sv
module spi_burst_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_MODE = 5'h00, A_FRM = 5'h04, A_CLK = 5'h08,
                         A_STAT = 5'h0C, A_DATA = 5'h10;
  // {cpol, cpha, lsb_first, divider, byte}
  localparam logic [18:0] VEC [6] = '{
    {3'b000, 8'd0, 8'hA5}, {3'b010, 8'd1, 8'h3C}, {3'b101, 8'd2, 8'h81},
    {3'b111, 8'd0, 8'h6E}, {3'b001, 8'd3, 8'hF0}, {3'b110, 8'd1, 8'h12}};

  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sck, mosi, miso, irq;
  int checks = 0, fails = 0;
  bit ended = 0;
  logic b_cpol = 0, b_cpha = 0;
  logic [7:0] cap = '0;
  logic [31:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = ~mosi;

  spi_burst_master dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
    .mosi(mosi), .miso(miso), .irq(irq));

  always @(sck) if (rst_n && sck == (b_cpol == b_cpha)) cap = {cap[6:0], mosi};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(A_STAT, s);
      if (s[0]) break;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_MODE, r); chk("R1 mode", r, 0);
    rd(A_STAT, r); chk("R1 status", r, 1);
    chk("R1 sck", sck, 0);
    chk("R1 irq", irq, 0);
    // R11 fixed frame length
    rd(A_CLK, r); chk("R11 length", r[4:0], 8);

    // R2 data writes in config mode are discarded
    wr(A_DATA, 32'h55);
    repeat (40) @(negedge clk);
    rd(A_STAT, r); chk("R2 cfg write ignored", r, 1);
    wr(A_MODE, 1);
    repeat (40) @(negedge clk);
    rd(A_STAT, r); chk("R2 nothing sent", r, 1);

    // main vectors: R5 R6 R4
    foreach (VEC[i]) begin
      wr(A_MODE, 2);
      b_cpol = VEC[i][18]; b_cpha = VEC[i][17];
      wr(A_FRM, {29'd0, VEC[i][17], VEC[i][18], VEC[i][16]});
      wr(A_CLK, {16'd0, VEC[i][15:8], 8'd0});
      wr(A_MODE, 1);
      wr(A_DATA, {24'd0, VEC[i][7:0]});
      wait_idle();
      chk("R4 sck rest", sck, VEC[i][18]);
      rd(A_DATA, r); chk("R6 rx byte", r, {24'd0, ~VEC[i][7:0]});
      chk("R5 mosi order", cap, VEC[i][16] ? {<<{VEC[i][7:0]}} : VEC[i][7:0]);
    end

    // R3 lock in active mode
    wr(A_MODE, 2); b_cpol = 0; b_cpha = 0;
    wr(A_FRM, 0); wr(A_CLK, 32'h100);
    wr(A_MODE, 1);
    wr(A_FRM, 32'h0000_100F);
    rd(A_FRM, r); chk("R3 frame lock", r, 32'h0000_1008);
    wr(A_CLK, 32'h500);
    rd(A_CLK, r); chk("R3 divider lock", r, 32'h108);

    // R9 threshold 2 with enable, R8 pops
    wr(A_DATA, 32'h11); wait_idle();
    rd(A_STAT, r); chk("R9 below flag", r[1], 0);
    chk("R9 below irq", irq, 0);
    wr(A_DATA, 32'h22); wait_idle();
    rd(A_STAT, r); chk("R9 reach flag", r[1], 1);
    chk("R9 reach irq", irq, 1);
    rd(A_DATA, r); chk("R8 pop first", r, 32'hEE);
    chk("R9 irq drop", irq, 0);
    rd(A_DATA, r); chk("R8 pop second", r, 32'hDD);
    rd(A_DATA, r); chk("R8 empty read", r, 0);
    rd(A_STAT, r); chk("R8 ready clear", r[2], 0);
    chk("R10 idle", r[0], 1);

    // R4 half-period with divider 2
    wr(A_MODE, 2); wr(A_CLK, 32'h200); wr(A_MODE, 1);
    wr(A_DATA, 32'h80);
    begin
      int n = 0;
      @(posedge sck);
      forever begin
        @(negedge clk);
        if (sck) n++; else break;
      end
      chk("R4 half period", n, 3);
    end
    wait_idle();

    // R7 overflow at the depth boundary
    wr(A_MODE, 2); wr(A_CLK, 32'h300); wr(A_MODE, 1);
    for (int k = 0; k < 5; k++) wr(A_DATA, k);
    rd(A_STAT, r); chk("R7 no overflow yet", r[3], 0);
    chk("R10 busy", r[0], 0);
    wr(A_DATA, 32'h99);
    rd(A_STAT, r); chk("R7 overflow set", r[3], 1);
    // R2 flush mid-burst
    wr(A_MODE, 2);
    rd(A_STAT, r); chk("R2 flush", r, 1);
    chk("R2 abort sck", sck, 0);
    finish_run();
  end
endmodule